// File: doc/BRIEF.md
# Ternary Carry-Select Adder

This block adds two signed balanced-ternary words and a carry-in trit with no clock and no state. The word is cut into fixed-width segments. The bottom segment is a plain ripple chain of one-trit full adders fed by the external carry-in. Every segment above it holds three ripple adders that work in parallel. Each of the three assumes a different incoming carry: minus one, zero or plus one.

A carry chain then walks up the segments. The true carry leaving one segment drives a one-hot three-way select in the next segment. That select picks the segment's sum trits and also its outgoing carry, so the carry path crosses one multiplexer per segment and not one full adder per trit. The result is `W` sum trits plus one carry trit. Together they hold `a + b + cin` exactly.

Top module: `tcsa_adder`

## Requirements
- R1: Each trit uses two bits: 2'b00 is zero, 2'b01 is +1 and 2'b11 is -1. Trit i of a word sits at bits [2i+1:2i], and trit 0 has weight 1.
- R2: The value of `sumOut`, plus 3^W times the value of `carryOut`, equals value(aIn) + value(bIn) + value(cIn) for every input combination.
- R3: Each segment above the lowest picks exactly one of its three speculative results. The pick is keyed on the true carry from the segment below: -1 picks the -1 version, 0 picks the 0 version and +1 picks the +1 version.
- R4: The same select picks the segment's outgoing carry. A carry produced in the lowest trit therefore reaches the top of the word and `carryOut`, for example all-P plus +1.
- R5: The lowest segment is a ripple adder that takes `cIn` as its carry-in. A carry-in of -1 or +1 changes the result by exactly that amount.
- R6: `W` and the segment width `SEG` are parameters (defaults 9 and 3), with W > SEG. When W is not a multiple of SEG, the word is padded with zero trits. The trit just above the word becomes `carryOut`, and the result still meets R2.
- R7: Every output trit uses only the three legal codes. The input code 2'b10 is read as zero.
- R8: The extreme sums are exact: all-P + all-P + P gives +3^W, and all-N + all-N + N gives -3^W.
- R9: The outputs depend only on the present inputs. All-zero inputs give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aIn | input | 2*W | First operand, W trits |
| bIn | input | 2*W | Second operand, W trits |
| cIn | input | 2 | Carry-in trit |
| sumOut | output | 2*W | Sum trits of the result |
| carryOut | output | 2 | Carry-out trit, weight 3^W |

## Verification
Every result is combinational, so it is due in the same clock period in which the operands change; no register lies on any path. The bench changes operands on the falling edge. It reads `sumOut` and `carryOut` one nanosecond after the next rising edge, which gives the speculative adders and the select chain more than half a period to settle. The expected values are computed with integer arithmetic, so the checks do not depend on any internal timing.

// File: rtl/tcsa_pkg.sv
`timescale 1ns/1ps
package tcsa_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_O = 2'b00;
  localparam trit_t TRIT_P = 2'b01;
  localparam trit_t TRIT_N = 2'b11;

  // one-hot strobes sent from the carry chain to a segment's sum select
  typedef struct packed {
    logic pickN;
    logic pickO;
    logic pickP;
  } selStrobe_t;

  function automatic int tritVal(trit_t t);
    case (t)
      TRIT_P:  return 1;
      TRIT_N:  return -1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/tcsa_full_adder.sv
`timescale 1ns/1ps
module tcsa_full_adder
  import tcsa_pkg::*;
(
  input  trit_t aIn,
  input  trit_t bIn,
  input  trit_t cIn,
  output trit_t sumOut,
  output trit_t carryOut
);
  int total;

  always_comb begin
    total = tritVal(aIn) + tritVal(bIn) + tritVal(cIn);
    case (total)
      3:       begin sumOut = TRIT_O; carryOut = TRIT_P; end
      2:       begin sumOut = TRIT_N; carryOut = TRIT_P; end
      1:       begin sumOut = TRIT_P; carryOut = TRIT_O; end
      -1:      begin sumOut = TRIT_N; carryOut = TRIT_O; end
      -2:      begin sumOut = TRIT_P; carryOut = TRIT_N; end
      -3:      begin sumOut = TRIT_O; carryOut = TRIT_N; end
      default: begin sumOut = TRIT_O; carryOut = TRIT_O; end
    endcase
  end
endmodule

// File: rtl/tcsa_ripple.sv
`timescale 1ns/1ps
module tcsa_ripple
  import tcsa_pkg::*;
#(
  parameter int SW = 3
) (
  input  logic [2*SW-1:0] aIn,
  input  logic [2*SW-1:0] bIn,
  input  trit_t           cIn,
  output logic [2*SW-1:0] sumOut,
  output trit_t           carryOut
);
  localparam int POW = 3 ** SW;

  trit_t [SW:0] chain;
  assign chain[0] = cIn;

  for (genvar i = 0; i < SW; i++) begin : g_cell
    tcsa_full_adder u_cell (
      .aIn     (aIn[2*i +: 2]),
      .bIn     (bIn[2*i +: 2]),
      .cIn     (chain[i]),
      .sumOut  (sumOut[2*i +: 2]),
      .carryOut(chain[i+1])
    );
  end

  assign carryOut = chain[SW];

  function automatic int segVal(input logic [2*SW-1:0] v);
    int acc = 0;
    int wgt = 1;
    for (int i = 0; i < SW; i++) begin
      acc += tritVal(v[2*i +: 2]) * wgt;
      wgt *= 3;
    end
    return acc;
  endfunction

  // the segment result across all cells must match the arithmetic sum
  always_comb begin
    p_seg_sum_r2: assert (segVal(sumOut) + POW * tritVal(carryOut)
                          == segVal(aIn) + segVal(bIn) + tritVal(cIn))
      else $error("segment sum mismatch");
  end
endmodule

// File: rtl/tcsa_datapath.sv
`timescale 1ns/1ps
module tcsa_datapath
  import tcsa_pkg::*;
#(
  parameter int W   = 9,
  parameter int SEG = 3,
  localparam int NSEG = (W + SEG - 1) / SEG,
  localparam int NT   = NSEG * SEG,
  localparam int NUP  = NSEG - 1
) (
  input  logic [2*NT-1:0]        aPad,
  input  logic [2*NT-1:0]        bPad,
  input  trit_t                  cIn,
  input  selStrobe_t [NUP-1:0]   pickVec,
  output logic [2*NT-1:0]        sumPad,
  output trit_t                  lowCarry,
  output trit_t [NUP-1:0][2:0]   specCarry
);
  // lowest segment: plain ripple
  tcsa_ripple #(.SW(SEG)) u_low (
    .aIn     (aPad[2*SEG-1:0]),
    .bIn     (bPad[2*SEG-1:0]),
    .cIn     (cIn),
    .sumOut  (sumPad[2*SEG-1:0]),
    .carryOut(lowCarry)
  );

  for (genvar g = 0; g < NUP; g++) begin : g_seg
    localparam int LO = 2 * SEG * (g + 1);
    logic [2:0][2*SEG-1:0] specSum;

    for (genvar v = 0; v < 3; v++) begin : g_spec
      localparam trit_t SPEC_C = (v == 0) ? TRIT_N : ((v == 1) ? TRIT_O : TRIT_P);
      tcsa_ripple #(.SW(SEG)) u_spec (
        .aIn     (aPad[LO +: 2*SEG]),
        .bIn     (bPad[LO +: 2*SEG]),
        .cIn     (SPEC_C),
        .sumOut  (specSum[v]),
        .carryOut(specCarry[g][v])
      );
    end

    assign sumPad[LO +: 2*SEG] = pickVec[g].pickN ? specSum[0] :
                                 pickVec[g].pickP ? specSum[2] :
                                 pickVec[g].pickO ? specSum[1] : '0;
  end

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      p_canon_sum_r7: assert (sumPad[2*i +: 2] != 2'b10)
        else $error("illegal sum trit code at %0d", i);
    end
  end
endmodule

// File: rtl/tcsa_carry_ctrl.sv
`timescale 1ns/1ps
module tcsa_carry_ctrl
  import tcsa_pkg::*;
#(
  parameter int NUP = 2
) (
  input  trit_t                lowCarry,
  input  trit_t [NUP-1:0][2:0] specCarry,
  output selStrobe_t [NUP-1:0] pickVec,
  output trit_t                carryOut
);
  trit_t chain;

  always_comb begin
    chain = lowCarry;
    for (int k = 0; k < NUP; k++) begin
      pickVec[k].pickN = (chain == TRIT_N);
      pickVec[k].pickO = (chain == TRIT_O);
      pickVec[k].pickP = (chain == TRIT_P);
      chain = pickVec[k].pickN ? specCarry[k][0] :
              pickVec[k].pickP ? specCarry[k][2] : specCarry[k][1];
    end
    carryOut = chain;
  end

  always_comb begin
    for (int k = 0; k < NUP; k++) begin
      // exactly one of the three speculative results is chosen
      p_pick_onehot_r3: assert ($onehot(pickVec[k]))
        else $error("segment %0d select not one-hot", k);
      // a larger carry-in never gives a smaller carry-out, and the spread is at most one
      p_carry_order_r4: assert (tritVal(specCarry[k][0]) <= tritVal(specCarry[k][1])
                                && tritVal(specCarry[k][1]) <= tritVal(specCarry[k][2])
                                && tritVal(specCarry[k][2]) - tritVal(specCarry[k][0]) <= 1)
        else $error("segment %0d speculative carries out of order", k);
    end
  end
endmodule

// File: rtl/tcsa_adder.sv
`timescale 1ns/1ps
module tcsa_adder
  import tcsa_pkg::*;
#(
  parameter int W   = 9,
  parameter int SEG = 3
) (
  input  logic [2*W-1:0] aIn,
  input  logic [2*W-1:0] bIn,
  input  logic [1:0]     cIn,
  output logic [2*W-1:0] sumOut,
  output logic [1:0]     carryOut
);
  localparam int NSEG = (W + SEG - 1) / SEG;
  localparam int NT   = NSEG * SEG;
  localparam int NUP  = NSEG - 1;

  logic [2*NT-1:0]      aPad;
  logic [2*NT-1:0]      bPad;
  logic [2*NT-1:0]      sumPad;
  trit_t                lowCarry;
  trit_t                chainCarry;
  trit_t [NUP-1:0][2:0] specCarry;
  selStrobe_t [NUP-1:0] pickVec;

  if (NT == W) begin : g_exact
    assign aPad     = aIn;
    assign bPad     = bIn;
    assign sumOut   = sumPad;
    assign carryOut = chainCarry;
  end else begin : g_padded
    assign aPad     = {{(2*(NT-W)){1'b0}}, aIn};
    assign bPad     = {{(2*(NT-W)){1'b0}}, bIn};
    assign sumOut   = sumPad[2*W-1:0];
    assign carryOut = sumPad[2*W +: 2];

    // the zero padding absorbs the carry in its first trit
    always_comb begin
      p_pad_clear_r6: assert (chainCarry == TRIT_O)
        else $error("carry escaped past padding");
      for (int i = W + 1; i < NT; i++) begin
        p_pad_high_r6: assert (sumPad[2*i +: 2] == TRIT_O)
          else $error("nonzero padding trit %0d", i);
      end
    end
  end

  tcsa_datapath #(.W(W), .SEG(SEG)) u_dp (
    .aPad     (aPad),
    .bPad     (bPad),
    .cIn      (cIn),
    .pickVec  (pickVec),
    .sumPad   (sumPad),
    .lowCarry (lowCarry),
    .specCarry(specCarry)
  );

  tcsa_carry_ctrl #(.NUP(NUP)) u_ctrl (
    .lowCarry (lowCarry),
    .specCarry(specCarry),
    .pickVec  (pickVec),
    .carryOut (chainCarry)
  );
endmodule

// File: tb/tcsa_adder_test.sv
`timescale 1ns/1ps
module tcsa_adder_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [17:0] aV, bV, sumV;
  logic [1:0]  cV, coV;
  logic [13:0] aO, bO, sumO;
  logic [1:0]  cO, coO;

  tcsa_adder #(.W(9), .SEG(3)) uut (
    .aIn(aV), .bIn(bV), .cIn(cV), .sumOut(sumV), .carryOut(coV));

  tcsa_adder #(.W(7), .SEG(3)) uutOdd (
    .aIn(aO), .bIn(bO), .cIn(cO), .sumOut(sumO), .carryOut(coO));

  function automatic int tv(logic [1:0] t);
    if (t == 2'b01) return 1;
    if (t == 2'b11) return -1;
    return 0;
  endfunction

  function automatic logic [1:0] vt(int v);
    if (v > 0) return 2'b01;
    if (v < 0) return 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [17:0] enc(int v, int n);
    logic [17:0] r = '0;
    int x = v;
    for (int i = 0; i < n; i++) begin
      int d = ((x % 3) + 3) % 3;
      if (d == 2) d = -1;
      r[2*i +: 2] = vt(d);
      x = (x - d) / 3;
    end
    return r;
  endfunction

  function automatic int dec(logic [17:0] v, int n);
    int acc = 0;
    int w = 1;
    for (int i = 0; i < n; i++) begin
      acc += tv(v[2*i +: 2]) * w;
      w *= 3;
    end
    return acc;
  endfunction

  function automatic bit legal(logic [17:0] v, int n);
    for (int i = 0; i < n; i++)
      if (v[2*i +: 2] == 2'b10) return 0;
    return 1;
  endfunction

  task automatic check(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // main instance: apply raw vectors, then compare with an integer expectation
  task automatic runMain(string req, logic [17:0] a, logic [17:0] b, logic [1:0] c, int exp);
    @(negedge clk);
    aV = a; bV = b; cV = c;
    @(posedge clk);
    #1;
    check(req, dec(sumV, 9) + 19683 * tv(coV), exp);
    check({req, " legal codes"}, int'(legal(sumV, 9) && coV != 2'b10), 1);
  endtask

  task automatic addMain(string req, int a, int b, int c);
    runMain(req, enc(a, 9), enc(b, 9), vt(c), a + b + c);
  endtask

  task automatic tZero();   // R9
    addMain("R9 zero", 0, 0, 0);
    check("R9 zero word", int'(sumV), 0);
  endtask

  task automatic tEncoding();   // R1
    logic [17:0] a = '0;
    a[9:8] = 2'b01;             // trit 4 = +1 -> 81
    runMain("R1 trit position", a, 18'b0, 2'b00, 81);
    a = '0;
    a[1:0] = 2'b11;             // trit 0 = -1
    runMain("R1 minus code", a, 18'b0, 2'b11, -2);
  endtask

  task automatic tRandom();   // R2
    for (int i = 0; i < 300; i++) begin
      int a = int'($urandom_range(0, 19682)) - 9841;
      int b = int'($urandom_range(0, 19682)) - 9841;
      int c = int'($urandom_range(0, 2)) - 1;
      addMain("R2 random", a, b, c);
    end
  endtask

  task automatic tSelect();   // R3: low segment carry of -1, 0, +1
    addMain("R3 low carry P", 13, 1, 0);
    addMain("R3 low carry N", -13, -1, 0);
    addMain("R3 low carry O", 5, 3, 0);
    addMain("R3 mixed", 13 + 27 * 13, 1, 0);
  endtask

  task automatic tChain();   // R4: carry crosses every segment
    addMain("R4 full propagate up", 9841, 1, 0);
    addMain("R4 full propagate down", -9841, -1, 0);
    addMain("R4 propagate via cin", 9841, 0, 1);
    check("R4 carry trit", tv(coV), 1);
  endtask

  task automatic tCin();   // R5
    addMain("R5 cin plus", 0, 0, 1);
    addMain("R5 cin minus", 0, 0, -1);
    addMain("R5 cin ripple", 1, 1, 1);
    addMain("R5 cin borrow", -4, 0, -1);
  endtask

  task automatic tInvalid();   // R7: code 2'b10 read as zero
    logic [17:0] a = enc(4, 9);
    a[5:4] = 2'b10;
    runMain("R7 illegal code as zero", a, enc(7, 9), 2'b00, 11);
  endtask

  task automatic tExtremes();   // R8
    addMain("R8 all P", 9841, 9841, 1);
    check("R8 max value", dec(sumV, 9) + 19683 * tv(coV), 19683);
    addMain("R8 all N", -9841, -9841, -1);
    addMain("R8 P plus N", 9841, -9841, 0);
  endtask

  task automatic tOdd();   // R6: W=7 with 3-trit segments
    for (int i = 0; i < 100; i++) begin
      int a = (i == 0) ? 1093  : ((i == 1) ? -1093 : int'($urandom_range(0, 2186)) - 1093);
      int b = (i == 0) ? 1093  : ((i == 1) ? -1093 : int'($urandom_range(0, 2186)) - 1093);
      int c = (i < 2) ? ((i == 0) ? 1 : -1) : int'($urandom_range(0, 2)) - 1;
      logic [17:0] ea = enc(a, 7);
      logic [17:0] eb = enc(b, 7);
      logic [17:0] so;
      @(negedge clk);
      aO = ea[13:0]; bO = eb[13:0]; cO = vt(c);
      @(posedge clk);
      #1;
      so = {4'b0, sumO};
      check("R6 padded width", dec(so, 7) + 2187 * tv(coO), a + b + c);
    end
  endtask

  initial begin
    aV = '0; bV = '0; cV = '0;
    aO = '0; bO = '0; cO = '0;
    repeat (2) @(posedge clk);
    tZero();
    tEncoding();
    tSelect();
    tChain();
    tCin();
    tInvalid();
    tExtremes();
    tRandom();
    tOdd();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule